// File: doc/BRIEF.md
# Three-Stage Multiply-Add Pipeline

This block computes `a*b + c` on unsigned operands for a stream of operand triples and takes a new triple on every clock. The work is split over three register stages. The first stage holds the two multiplicands. The second stage holds their full-width product together with the matching addend. The third stage holds the sum. A valid flag moves alongside the data, so `out_valid` marks exactly the cycles whose `out_sum` belongs to a real triple. The latency is fixed at three clocks. Results leave in the same order the triples arrived.

The addend can reach the block in one of two ways, and the parameter `ALIGN_ADDEND` chooses between them. With `ALIGN_ADDEND=1`, the addend arrives in the same cycle as its multiplicands, and an internal register delays it by one stage. With `ALIGN_ADDEND=0`, the source presents the addend one cycle after the multiplicands, and the addend goes straight into the second stage.

The stream interface carries a valid flag only. There is no back-pressure path. The sink must accept every result in the cycle it appears, and the source may present a triple on every clock.

Top module: `mac3_pipe`

## Requirements
- R1: A triple can be accepted on every rising edge. N triples on consecutive edges give N results on consecutive cycles, with no gap between them.
- R2: A triple is sampled on the rising edge where `in_valid` is 1. Its result appears, with `out_valid`=1, right after the third rising edge, counting the sampling edge as the first.
- R3: `out_sum` equals `in_a*in_b + in_c` exactly. It is computed as an unsigned 2W+1-bit value, so all-ones operands with W=8 give 255*255+255 = 65280 without overflow.
- R4: With `ALIGN_ADDEND=1`, `in_c` is sampled on the same edge as `in_a` and `in_b`.
- R5: With `ALIGN_ADDEND=0`, the addend of a triple is the value of `in_c` on the rising edge one clock after its multiplicands were sampled.
- R6: A cycle where `in_valid` is 0 produces exactly one cycle with `out_valid`=0, three clocks later. The values on `in_a`, `in_b` and `in_c` in that cycle cause no result.
- R7: `rst` is synchronous and active high. It clears the valid flag of every stage, so `out_valid` is 0 after a reset edge. Triples still in flight at that edge never produce a result.
- R8: Five triples presented on five consecutive edges complete within 3+(5-1)=7 clocks. The last result appears right after the seventh rising edge, counting the first sampling edge as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the multiplicands (and, in aligned mode, the addend) |
| in_a | input | W | Multiplicand, unsigned |
| in_b | input | W | Multiplicand, unsigned |
| in_c | input | W | Addend, unsigned; its timing is set by `ALIGN_ADDEND` |
| out_valid | output | 1 | Marks a real result on `out_sum` |
| out_sum | output | 2W+1 | Product plus addend |

## Verification
Two instances are driven side by side, one in each addend mode, and they must give the same results. This shows that the late addend is paired with its own product and not with the product of a neighbouring triple.

- A directed burst of five back-to-back triples tests throughput and the 3+(n-1) completion time.
- All-ones operands test the result width.
- Alternating valid cycles show whether bubbles are kept in place or collapsed.
- A reset issued with triples in flight shows whether stale results leak out.

A long random stream with random gaps and occasional resets then mixes all of these cases.

// File: rtl/mp_pkg.sv
`timescale 1ns/1ps
package mp_pkg;
  // Width of the final result: full product plus one carry bit.
  function automatic int sum_width(input int w);
    return 2 * w + 1;
  endfunction

  // Width of the product register.
  function automatic int prod_width(input int w);
    return 2 * w;
  endfunction
endpackage

// File: rtl/mp_stage_in.sv
`timescale 1ns/1ps
module mp_stage_in #(
  parameter int W            = 8,
  parameter bit ALIGN_ADDEND = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic         v_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o
);
  logic         v_q;
  logic [W-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_i;
  end

  // Data registers load only for real triples.
  always_ff @(posedge clk) begin
    if (v_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  generate
    if (ALIGN_ADDEND) begin : g_delay_c
      // Addend arrives with its multiplicands: hold it one stage.
      logic [W-1:0] c_q;
      always_ff @(posedge clk) begin
        if (v_i) c_q <= c_i;
      end
      assign c_o = c_q;
    end else begin : g_late_c
      // Addend arrives one cycle later: it goes straight to stage 2.
      assign c_o = c_i;
    end
  endgenerate

  assign v_o = v_q;
  assign a_o = a_q;
  assign b_o = b_q;

  // R7: a reset edge clears the first-stage flag.
  assert_reset_clears_s1_R7: assert property (@(posedge clk) rst |=> !v_o);
endmodule

// File: rtl/mp_stage_mul.sv
`timescale 1ns/1ps
module mp_stage_mul #(
  parameter int W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              v_i,
  input  logic [W-1:0]                      a_i,
  input  logic [W-1:0]                      b_i,
  input  logic [W-1:0]                      c_i,
  output logic                              v_o,
  output logic [mp_pkg::prod_width(W)-1:0]  p_o,
  output logic [W-1:0]                      c_o
);
  localparam int PW = mp_pkg::prod_width(W);

  logic          v_q;
  logic [PW-1:0] p_q;
  logic [W-1:0]  c_q;
  logic [PW-1:0] a_ext, b_ext;

  assign a_ext = {{(PW-W){1'b0}}, a_i};
  assign b_ext = {{(PW-W){1'b0}}, b_i};

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_i;
  end

  // Product and addend are captured on the same edge, so they stay paired.
  always_ff @(posedge clk) begin
    if (v_i) begin
      p_q <= a_ext * b_ext;
      c_q <= c_i;
    end
  end

  assign v_o = v_q;
  assign p_o = p_q;
  assign c_o = c_q;

  // R7: a reset edge clears the second-stage flag.
  assert_reset_clears_s2_R7: assert property (@(posedge clk) rst |=> !v_o);
endmodule

// File: rtl/mp_stage_add.sv
`timescale 1ns/1ps
module mp_stage_add #(
  parameter int W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             v_i,
  input  logic [mp_pkg::prod_width(W)-1:0] p_i,
  input  logic [W-1:0]                     c_i,
  output logic                             v_o,
  output logic [mp_pkg::sum_width(W)-1:0]  s_o
);
  localparam int PW = mp_pkg::prod_width(W);
  localparam int SW = mp_pkg::sum_width(W);

  logic          v_q;
  logic [SW-1:0] s_q;

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_i;
  end

  // One extra bit above the product absorbs the carry of the addition.
  always_ff @(posedge clk) begin
    if (v_i) s_q <= {1'b0, p_i} + {{(SW-W){1'b0}}, c_i};
  end

  assign v_o = v_q;
  assign s_o = s_q;

  // R3: the stored sum never wraps below the product it came from.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (s_o >= {1'b0, $past(p_i)}));
endmodule

// File: rtl/mac3_pipe.sv
`timescale 1ns/1ps
module mac3_pipe #(
  parameter int W            = 8,
  parameter bit ALIGN_ADDEND = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [W-1:0]                    in_a,
  input  logic [W-1:0]                    in_b,
  input  logic [W-1:0]                    in_c,
  output logic                            out_valid,
  output logic [mp_pkg::sum_width(W)-1:0] out_sum
);
  localparam int PW = mp_pkg::prod_width(W);
  localparam int SW = mp_pkg::sum_width(W);

  logic          s1_v, s2_v;
  logic [W-1:0]  s1_a, s1_b, s1_c;
  logic [PW-1:0] s2_p;
  logic [W-1:0]  s2_c;

  mp_stage_in #(.W(W), .ALIGN_ADDEND(ALIGN_ADDEND)) u_in (
    .clk(clk), .rst(rst), .v_i(in_valid), .a_i(in_a), .b_i(in_b), .c_i(in_c),
    .v_o(s1_v), .a_o(s1_a), .b_o(s1_b), .c_o(s1_c)
  );

  mp_stage_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .v_i(s1_v), .a_i(s1_a), .b_i(s1_b), .c_i(s1_c),
    .v_o(s2_v), .p_o(s2_p), .c_o(s2_c)
  );

  mp_stage_add #(.W(W)) u_add (
    .clk(clk), .rst(rst), .v_i(s2_v), .p_i(s2_p), .c_i(s2_c),
    .v_o(out_valid), .s_o(out_sum)
  );

  // Checker state: clean edges since reset, saturating at the pipeline depth.
  logic [1:0]    clean_edges;
  logic [SW-1:0] chk_a, chk_b, chk_c;

  always_ff @(posedge clk) begin
    if (rst)                   clean_edges <= 2'd0;
    else if (clean_edges != 3) clean_edges <= clean_edges + 2'd1;
  end

  assign chk_a = {{(SW-W){1'b0}}, in_a};
  assign chk_b = {{(SW-W){1'b0}}, in_b};
  assign chk_c = {{(SW-W){1'b0}}, in_c};

  // R2, R6: the output flag repeats the input flag three edges later.
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (clean_edges == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  generate
    if (ALIGN_ADDEND) begin : g_chk_align
      // R3, R4: addend sampled together with the multiplicands.
      assert_result_R4: assert property (@(posedge clk) disable iff (rst)
        (clean_edges == 2'd3 && out_valid) |->
        (out_sum == $past(chk_a, 3) * $past(chk_b, 3) + $past(chk_c, 3)));
    end else begin : g_chk_late
      // R3, R5: addend sampled one edge after the multiplicands.
      assert_result_R5: assert property (@(posedge clk) disable iff (rst)
        (clean_edges == 2'd3 && out_valid) |->
        (out_sum == $past(chk_a, 3) * $past(chk_b, 3) + $past(chk_c, 2)));
    end
  endgenerate
endmodule

// File: tb/mac3_pipe_test.sv
`timescale 1ns/1ps
module mac3_pipe_test;
  localparam int W  = 8;
  localparam int SW = 2 * W + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [W-1:0]  in_a, in_b, in_c, in_c_late;
  logic          out_valid, late_valid;
  logic [SW-1:0] out_sum, late_sum;

  always #4 clk = ~clk;  // 125 MHz

  mac3_pipe #(.W(W), .ALIGN_ADDEND(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_c(in_c), .out_valid(out_valid), .out_sum(out_sum)
  );

  mac3_pipe #(.W(W), .ALIGN_ADDEND(1'b0)) uut_late (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_c(in_c_late), .out_valid(late_valid), .out_sum(late_sum)
  );

  int checks = 0;
  int errors = 0;
  int n = 0;
  int vcount = 0;
  int first_v = -1;
  int last_v = -1;
  bit done = 1'b0;

  // Ring of the last four applied triples, indexed by step number mod 4.
  logic         rv [4];
  logic [W-1:0] ra [4];
  logic [W-1:0] rb [4];
  logic [W-1:0] rc [4];

  function automatic logic [SW-1:0] model(input logic [W-1:0] a, b, c);
    return SW'(a) * SW'(b) + SW'(c);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: check outputs due now, then drive the next inputs.
  task automatic step(input bit v, input logic [W-1:0] a, b, c, input bit r);
    int k;
    logic [SW-1:0] e;
    @(negedge clk);
    if (n >= 3) begin
      k = (n + 1) % 4;  // slot applied three steps ago
      e = model(ra[k], rb[k], rc[k]);
      chk(out_valid === rv[k], "R2 R6 R7 valid (aligned)", int'(out_valid), int'(rv[k]));
      chk(late_valid === rv[k], "R5 R6 R7 valid (late)", int'(late_valid), int'(rv[k]));
      if (rv[k]) begin
        chk(out_sum === e, "R3 R4 sum (aligned)", int'(out_sum), int'(e));
        chk(late_sum === e, "R3 R5 sum (late)", int'(late_sum), int'(e));
      end
    end
    if (out_valid === 1'b1) begin
      vcount++;
      if (first_v < 0) first_v = n;
      last_v = n;
    end
    if (r) for (int i = 0; i < 4; i++) rv[i] = 1'b0;
    rst       = r;
    in_valid  = v;
    in_a      = a;
    in_b      = b;
    in_c      = c;
    in_c_late = rc[(n + 3) % 4];  // addend of the previous step's triple
    rv[n % 4] = v && !r;
    ra[n % 4] = a;
    rb[n % 4] = b;
    rc[n % 4] = c;
    n++;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      rv[i] = 1'b0; ra[i] = '0; rb[i] = '0; rc[i] = '0;
    end
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_c = '0; in_c_late = '0;

    // Reset state
    step(1'b0, 8'd0, 8'd0, 8'd0, 1'b1);
    step(1'b1, 8'd9, 8'd9, 8'd9, 1'b1);
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
    chk(late_valid === 1'b0, "R7 late out_valid after reset", int'(late_valid), 0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 8'd0, 8'd0, 1'b0);

    // R8 / R1: five back-to-back triples
    vcount = 0; first_v = -1; last_v = -1;
    n0 = n;
    for (int i = 1; i <= 5; i++)
      step(1'b1, 8'(i), 8'(i + 10), 8'(i * 3), 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 8'hAA, 8'h55, 8'h33, 1'b0);
    chk(vcount == 5, "R1 five consecutive results", vcount, 5);
    chk(first_v == n0 + 3, "R2 first result after third edge", first_v - n0, 3);
    chk(last_v == n0 + 7, "R8 last result at clock 7", last_v - n0, 7);

    // R3: all-ones operands, then all zeros
    step(1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0);
    step(1'b1, 8'h00, 8'h00, 8'h00, 1'b0);
    step(1'b1, 8'hFF, 8'h01, 8'hFF, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0);

    // R6: alternating bubbles with busy data lines
    for (int i = 0; i < 10; i++)
      step(i % 2 == 0, 8'(i * 7 + 1), 8'(i * 5 + 2), 8'(i + 100), 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'd1, 8'd1, 8'd1, 1'b0);

    // R7: reset with triples in flight
    step(1'b1, 8'd20, 8'd30, 8'd40, 1'b0);
    step(1'b1, 8'd21, 8'd31, 8'd41, 1'b0);
    step(1'b0, 8'd0, 8'd0, 8'd0, 1'b1);
    vcount = 0;
    for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 8'd0, 8'd0, 1'b0);
    chk(vcount == 0, "R7 in-flight triples dropped", vcount, 0);

    // Random stream with gaps and rare resets
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) < 7, 8'($urandom), 8'($urandom), 8'($urandom),
           ($urandom % 500) == 0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 8'd0, 8'd0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule